// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block supervises a host processor through the traffic it places on a two-wire serial bus. The host needs no dedicated service pin. It keeps the watchdog quiet by putting a start condition and then a stop condition on the bus. The block samples the clock and data lines on the system clock and recognises both bus conditions. Each start-then-stop pair clears an interval counter. That counter advances once per tick enable. When it reaches the selected limit, the block drives a fixed-length pulse on its watchdog output and then begins a new interval.

A two-bit select input picks one of three interval lengths, or turns the watchdog off. The limits are parameters counted in ticks, so a 1 ms tick gives the usual 25 ms, 200 ms and 1.4 s settings. Any change of the select input restarts the interval. A start that no stop follows does not service the timer. A stop that no start precedes does not service it either.

Top module: `bus_watchdog`

## Requirements
- R1: Select code 2'b00 gives an interval of LIMIT_SHORT ticks, 2'b01 gives LIMIT_MID ticks and 2'b10 gives LIMIT_LONG ticks. `wdo` goes high on the clock edge that takes the limit-th counted tick after the last clear or after reset.
- R2: A start is SDA going 1 to 0 between two consecutive clock samples while SCL is 1 in both samples. A stop is SDA going 0 to 1 under the same SCL condition.
- R3: A stop that follows a start clears the interval counter on the clock edge that samples the stop. The next `wdo` rise then comes limit ticks later.
- R4: A stop with no start since reset or since the last service has no effect on the counter.
- R5: A start with no stop after it leaves the counter running.
- R6: The `wdo` pulse lasts PULSE_TICKS ticks. Counting then restarts from zero, so with no service the pulses repeat every limit + PULSE_TICKS ticks.
- R7: A change of `ivl_sel` clears the counter on the next clock edge and times the new interval from there.
- R8: Select code 2'b11 disables the watchdog: `wdo` stays low and the counter holds at zero.
- R9: Cycles with `tick_en` low neither advance the interval nor shorten the pulse.
- R10: A service or a select change during a pulse ends the pulse on the next edge and starts a new interval.
- R11: While `rst` is high, `wdo` is low, both counters are zero, no start is pending and the sampled bus lines read idle-high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timebase enable; one counted tick per high cycle |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| ivl_sel | input | 2 | Interval select: 00 short, 01 mid, 10 long, 11 off |
| wdo | output | 1 | Watchdog timeout pulse, active high |

## Verification
The bus is driven with four patterns: full start-then-stop services, a lone stop, a lone start, and data changes while SCL is low. Only the first may move the next timeout. A lone stop and a lone start each fall inside a running interval, and the expected pulse time stays the same, so any service taken by mistake shows up as a shifted edge. Each select code is timed from a mid-count change, which separates R7's clear from R1's limit decode. Gated ticks and a service in the middle of a pulse check that the rise cycle and the pulse width respond to each cause separately.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  typedef enum logic [1:0] {
    IVL_SHORT = 2'b00,
    IVL_MID   = 2'b01,
    IVL_LONG  = 2'b10,
    IVL_OFF   = 2'b11
  } ivl_sel_e;

  // Interval length in ticks for a select code; zero means disabled.
  function automatic int unsigned ivl_limit(input logic [1:0] sel,
                                            input int unsigned t_short,
                                            input int unsigned t_mid,
                                            input int unsigned t_long);
    case (sel)
      IVL_SHORT: return t_short;
      IVL_MID:   return t_mid;
      IVL_LONG:  return t_long;
      default:   return 0;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bwd_bus_cond.sv
module bwd_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  // Previous sample of both lines; idle bus reads high.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  logic scl_held;
  assign scl_held = scl_q & scl_i;

  assign start_o = scl_held &  sda_q & ~sda_i;
  assign stop_o  = scl_held & ~sda_q &  sda_i;

  // R2: data cannot rise and fall in the same sample pair
  assert_cond_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o));

endmodule

// File: rtl/bwd_kick_seq.sv
module bwd_kick_seq (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  output logic kick_o
);

  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst)          armed_q <= 1'b0;
    else if (start_i) armed_q <= 1'b1;
    else if (stop_i)  armed_q <= 1'b0;
  end

  assign kick_o = stop_i & armed_q;

  // R5: a pending start exists only because a start was seen
  assert_arm_from_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(start_i));

  // R3: a service consumes the pending start
  assert_kick_disarms_R3: assert property (@(posedge clk) disable iff (rst)
    kick_o |=> !armed_q);

  // R4: a stop without a pending start never services
  assert_lone_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !armed_q) |-> !kick_o);

endmodule

// File: rtl/bwd_timer.sv
module bwd_timer
  import bwd_pkg::*;
#(
  parameter int unsigned LIMIT_SHORT = 25,
  parameter int unsigned LIMIT_MID   = 200,
  parameter int unsigned LIMIT_LONG  = 1400,
  parameter int unsigned PULSE_TICKS = 16,
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned PCNT_W      = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  input  logic       kick_i,
  output logic       wdo_o
);

  logic [1:0]        sel_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic              pulse_q;

  logic [CNT_W-1:0]  limit_w;
  logic              off_w;
  logic              sel_change_w;
  logic              clear_w;
  logic              expire_w;
  logic              pulse_end_w;

  assign limit_w      = CNT_W'(ivl_limit(sel_q, LIMIT_SHORT, LIMIT_MID, LIMIT_LONG));
  assign off_w        = (sel_q == IVL_OFF);
  assign sel_change_w = (sel_i != sel_q);
  assign clear_w      = kick_i | sel_change_w;
  assign expire_w     = tick_i & !off_w & !pulse_q & (cnt_q == limit_w - 1'b1);
  assign pulse_end_w  = tick_i & pulse_q & (pcnt_q == PCNT_W'(PULSE_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= sel_i;
      cnt_q   <= '0;
      pcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (clear_w) begin
        cnt_q   <= '0;
        pcnt_q  <= '0;
        pulse_q <= 1'b0;
      end else if (tick_i && !off_w) begin
        if (pulse_q) begin
          if (pulse_end_w) begin
            pulse_q <= 1'b0;
            pcnt_q  <= '0;
            cnt_q   <= '0;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end else if (expire_w) begin
          pulse_q <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign wdo_o = pulse_q;

  // R1: the interval counter never passes the selected limit
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    !off_w |-> (cnt_q < limit_w));

  // R6: the pulse counter stays below the pulse length
  assert_pcnt_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    pcnt_q < PCNT_W'(PULSE_TICKS));

  // R7, R10: a clear leaves an idle, zeroed timer
  assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (rst)
    clear_w |=> (cnt_q == '0 && !pulse_q));

  // R8: a disabled watchdog is silent and held
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    off_w |-> (!pulse_q && cnt_q == '0));

  // R9: no timer state moves on a cycle without a tick unless cleared
  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clear_w) |=> ($stable(cnt_q) && $stable(pcnt_q) && $stable(pulse_q)));

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
  import bwd_pkg::*;
#(
  parameter int unsigned LIMIT_SHORT = 25,
  parameter int unsigned LIMIT_MID   = 200,
  parameter int unsigned LIMIT_LONG  = 1400,
  parameter int unsigned PULSE_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] ivl_sel,
  output logic       wdo
);

  localparam int unsigned MAX_LIMIT = max3(LIMIT_SHORT, LIMIT_MID, LIMIT_LONG);
  localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);
  localparam int unsigned PCNT_W    = $clog2(PULSE_TICKS + 1);

  logic start_w;
  logic stop_w;
  logic kick_w;

  bwd_bus_cond u_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_w),
    .stop_o  (stop_w)
  );

  bwd_kick_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_w),
    .stop_i  (stop_w),
    .kick_o  (kick_w)
  );

  bwd_timer #(
    .LIMIT_SHORT (LIMIT_SHORT),
    .LIMIT_MID   (LIMIT_MID),
    .LIMIT_LONG  (LIMIT_LONG),
    .PULSE_TICKS (PULSE_TICKS),
    .CNT_W       (CNT_W),
    .PCNT_W      (PCNT_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_en),
    .sel_i  (ivl_sel),
    .kick_i (kick_w),
    .wdo_o  (wdo)
  );

  // R11: the output is low through reset
  assert_reset_low_R11: assert property (@(posedge clk)
    rst |=> !wdo);

endmodule

// File: tb/test_bus_watchdog.sv
module test_bus_watchdog;

  localparam int LS = 25;
  localparam int LM = 200;
  localparam int LL = 1400;
  localparam int PW = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       scl_i = 1'b1;
  logic       sda_i = 1'b1;
  logic [1:0] ivl_sel = 2'b00;
  logic       wdo;

  bus_watchdog #(.LIMIT_SHORT(LS), .LIMIT_MID(LM), .LIMIT_LONG(LL), .PULSE_TICKS(PW))
    i_bus_watchdog (.clk(clk), .rst(rst), .tick_en(tick_en), .scl_i(scl_i),
                    .sda_i(sda_i), .ivl_sel(ivl_sel), .wdo(wdo));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int rise; int width; string req; } exp_t;
  exp_t exp_q[$];

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: pops expected pulses and compares rise cycle and width.
  logic wdo_prev = 1'b0;
  int   rise_at = 0;
  int   want_w = 0;
  string cur_req = "";
  always @(negedge clk) begin
    if (wdo && !wdo_prev) begin
      rise_at = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected pulse", cyc, -1);
        want_w = 0;
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc == e.rise, e.req, cyc, e.rise);
        want_w = e.width;
        cur_req = e.req;
      end
    end
    if (!wdo && wdo_prev && want_w != 0)
      check((cyc - rise_at) == want_w, {cur_req, " R6 width"}, cyc - rise_at, want_w);
    wdo_prev = wdo;
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Start then stop; returns cycle of the negedge that drove the stop.
  task automatic kick(output int c);
    step(); sda_i = 1'b0;
    step(); scl_i = 1'b0;
    step(); scl_i = 1'b1;
    step(); sda_i = 1'b1; c = cyc;
  endtask

  task automatic stop_only();
    step(); scl_i = 1'b0;
    step(); sda_i = 1'b0;
    step(); scl_i = 1'b1;
    step(); sda_i = 1'b1;
  endtask

  task automatic start_only();
    step(); sda_i = 1'b0;
    step(); scl_i = 1'b0;
    step(); sda_i = 1'b1;
    step(); scl_i = 1'b1;
  endtask

  task automatic push(input int r, input int w, input string req);
    exp_t e;
    e.rise = r; e.width = w; e.req = req;
    exp_q.push_back(e);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog timeout", cyc, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin : driver
    int c0, c1, c2, c3, c4, c5, c6, p;
    repeat (4) step();
    check(wdo == 1'b0, "R11 reset low", wdo, 0);
    step(); rst = 1'b0; c0 = cyc;
    // R1 short interval from reset; R6 repeat period
    push(c0 + LS, PW, "R1 short");
    push(c0 + LS + PW + LS, PW, "R6 repeat");
    // R4 lone stop and R5 lone start inside the first interval: no shift
    stop_only();
    start_only();
    wait_until(c0 + LS + PW + LS + PW + 3);
    // R3 repeated services hold off the pulse; R2 conditions decoded
    for (int k = 0; k < 6; k++) begin
      kick(c1);
      repeat (12) step();
    end
    push(c1 + 1 + LS, PW, "R3 service");
    wait_until(c1 + 1 + LS + PW + 8);
    // R7 select change mid-count times the mid interval
    ivl_sel = 2'b01; c2 = cyc;
    push(c2 + 1 + LM, PW, "R7 select change / R1 mid");
    wait_until(c2 + 1 + LM + PW + 3);
    // R8 disabled
    ivl_sel = 2'b11; c3 = cyc;
    repeat (1500) step();
    check(wdo == 1'b0, "R8 off silent", wdo, 0);
    // R9 gated ticks delay the expiry by the gated cycles
    ivl_sel = 2'b00; tick_en = 1'b0; c4 = cyc;
    repeat (10) step();
    tick_en = 1'b1;
    p = c4 + 10 + LS;
    // R10 service at p+6 ends the pulse after 7 cycles
    push(p, 7, "R9 gated / R10 cut pulse");
    wait_until(p + 2);
    check(wdo == 1'b1, "R9 pulse active", wdo, 1);
    kick(c5);
    step();
    check(wdo == 1'b0, "R10 pulse ended", wdo, 0);
    push(c5 + 1 + LS, PW, "R10 new interval");
    wait_until(c5 + 1 + LS + PW + 3);
    // R1 long interval
    ivl_sel = 2'b10; c6 = cyc;
    push(c6 + 1 + LL, PW, "R1 long");
    wait_until(c6 + 1 + LL + PW + 4);
    ivl_sel = 2'b11;
    repeat (5) step();
    check(exp_q.size() == 0, "R1 missing pulses", exp_q.size(), 0);
    check(wdo == 1'b0, "R8 off after long", wdo, 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule